// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic core of a small accumulator-style processor. It holds the accumulator and two index registers, and it keeps the carry, zero, overflow and negative flags. Each operation is presented as an opcode and an operand byte, qualified by a valid strobe. One cycle later the block raises a done pulse. In that same cycle the target register or the memory-result byte holds the new value, and the flags have been updated.

The datapath has two stages. An optional modify stage shifts, rotates, increments or decrements a byte taken from the operand or from the accumulator. An accumulator stage then loads, adds, applies logic, compares or bit-tests. A fused read-modify-write operation runs both stages in one cycle and passes the modify stage's carry into the accumulator stage. Subtraction reuses the adder with the operand inverted. Decimal arithmetic, address generation and instruction decode sit outside this block.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted and directly after it, the accumulator, both index registers, the memory-result byte, all four flags and both output strobes read zero.
- R2: A done pulse appears on the clock edge that follows a valid strobe. Registers, flags and the memory-result byte change only on that edge. With no strobe, nothing changes and the done pulse stays low.
- R3: Loads (opcode 0 into A, 1 into X, 2 into Y, 3 into both A and X) copy the operand. They set Z when the value is zero and set N from bit 7, and they hold C and V.
- R4: Add (opcode 4) forms A + operand + C. C takes the carry-out. V is set when both addends share a sign bit and the sum's sign bit differs from it. Z and N follow the sum.
- R5: Subtract (opcode 5) is the add with the operand inverted bitwise, so a clear C takes one extra away.
- R6: AND, OR and XOR with A (opcodes 6, 7, 8) write A and set Z and N from it, and they hold C and V.
- R7: Compare against A, X or Y (opcodes 9, 10, 11) sets C when the register is greater than or equal to the operand, unsigned. It sets Z on equality and sets N to bit 7 of the difference modulo 256. It changes no register and holds V.
- R8: Bit test (opcode 12) sets Z when A AND operand is zero, copies operand bit 6 into V and operand bit 7 into N, and leaves A unchanged.
- R9: Shift left (opcode 13 on A, 17 on the operand) moves bit 7 into C. Shift right (opcode 14 on A, 18 on the operand) moves bit 0 into C and always clears N. Z and N follow the result.
- R10: Rotate left (15 on A, 19 on the operand) feeds the old C into bit 0, and rotate right (16 on A, 20 on the operand) feeds it into bit 7. The bit shifted out becomes the new C.
- R11: Increment (21) and decrement (22) of the operand wrap modulo 256, write the memory-result byte, and change only Z and N.
- R12: The fused operations write the modified byte to the memory-result output and then combine it with A: 23 shifts left then ORs, 24 shifts right then XORs, 25 rotates left then ANDs, 26 rotates right then adds with the rotate's carry, 27 decrements then compares with A, 28 increments then subtracts. The carry from the first step feeds the second.
- R13: The memory-write strobe pulses with the done pulse exactly for opcodes 17 to 28. Opcodes 29 to 31 still produce a done pulse but change no register, flag or memory-result byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation strobe |
| inOp | input | 5 | Opcode |
| inOperand | input | 8 | Operand byte |
| outValid | output | 1 | Done pulse, one cycle after the strobe |
| outMemWr | output | 1 | Memory-result byte was written this cycle |
| outMem | output | 8 | Memory-result byte |
| regA | output | 8 | Accumulator |
| regX | output | 8 | X index register |
| regY | output | 8 | Y index register |
| flagC | output | 1 | Carry flag |
| flagZ | output | 1 | Zero flag |
| flagV | output | 1 | Overflow flag |
| flagN | output | 1 | Negative flag |

## Verification
Some properties are checked on every cycle: the one-cycle done timing, the stillness of all state when no strobe arrives, register preservation under compare and bit test, C and V holding through logic operations, N cleared by right shifts, the increment result on the memory byte, and the memory strobe implying a done pulse. The arithmetic rules need the bench's scenarios: carry and overflow at the sign and carry boundaries, borrow through a clear carry, the carry chained through fused operations, and results that wrap. The bench scenarios also compare every output against a behavioural model over a long run of random opcodes.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_LDA = 5'd0,  OP_LDX = 5'd1,  OP_LDY = 5'd2,  OP_LAX = 5'd3,
    OP_ADC = 5'd4,  OP_SBC = 5'd5,  OP_AND = 5'd6,  OP_ORA = 5'd7,
    OP_EOR = 5'd8,  OP_CMP = 5'd9,  OP_CPX = 5'd10, OP_CPY = 5'd11,
    OP_BIT = 5'd12, OP_SLA = 5'd13, OP_SRA = 5'd14, OP_RLA_A = 5'd15,
    OP_RRA_A = 5'd16, OP_SLM = 5'd17, OP_SRM = 5'd18, OP_RLM = 5'd19,
    OP_RRM = 5'd20, OP_INM = 5'd21, OP_DEM = 5'd22, OP_FSO = 5'd23,
    OP_FSX = 5'd24, OP_FRA = 5'd25, OP_FRD = 5'd26, OP_FDC = 5'd27,
    OP_FIS = 5'd28
  } aluOpcode_e;

  typedef enum logic [2:0] {
    MOD_NONE, MOD_SHL, MOD_SHR, MOD_ROL, MOD_ROR, MOD_INC, MOD_DEC
  } modKind_e;

  typedef enum logic [2:0] {
    ACC_PASS, ACC_LOAD, ACC_ADD, ACC_AND, ACC_OR, ACC_XOR, ACC_CMP, ACC_BIT
  } accKind_e;

  typedef enum logic [1:0] { SEL_A, SEL_X, SEL_Y } regSel_e;

  typedef struct packed {
    logic     fire;
    logic     flagWr;
    modKind_e modKind;
    logic     modFromAcc;
    accKind_e accKind;
    logic     invert;
    regSel_e  cmpSel;
    logic     wrA;
    logic     wrX;
    logic     wrY;
    logic     wrMem;
  } aluCtrl_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic            inValid,
  input  logic [OP_W-1:0] inOp,
  output aluCtrl_t        ctrl
);

  always_comb begin
    ctrl            = '0;
    ctrl.fire       = inValid;
    ctrl.flagWr     = 1'b1;
    ctrl.modKind    = MOD_NONE;
    ctrl.accKind    = ACC_PASS;
    ctrl.cmpSel     = SEL_A;
    case (inOp)
      OP_LDA:   begin ctrl.accKind = ACC_LOAD; ctrl.wrA = 1'b1; end
      OP_LDX:   begin ctrl.accKind = ACC_LOAD; ctrl.wrX = 1'b1; end
      OP_LDY:   begin ctrl.accKind = ACC_LOAD; ctrl.wrY = 1'b1; end
      OP_LAX:   begin ctrl.accKind = ACC_LOAD; ctrl.wrA = 1'b1; ctrl.wrX = 1'b1; end
      OP_ADC:   begin ctrl.accKind = ACC_ADD; ctrl.wrA = 1'b1; end
      OP_SBC:   begin ctrl.accKind = ACC_ADD; ctrl.invert = 1'b1; ctrl.wrA = 1'b1; end
      OP_AND:   begin ctrl.accKind = ACC_AND; ctrl.wrA = 1'b1; end
      OP_ORA:   begin ctrl.accKind = ACC_OR;  ctrl.wrA = 1'b1; end
      OP_EOR:   begin ctrl.accKind = ACC_XOR; ctrl.wrA = 1'b1; end
      OP_CMP:   begin ctrl.accKind = ACC_CMP; ctrl.cmpSel = SEL_A; end
      OP_CPX:   begin ctrl.accKind = ACC_CMP; ctrl.cmpSel = SEL_X; end
      OP_CPY:   begin ctrl.accKind = ACC_CMP; ctrl.cmpSel = SEL_Y; end
      OP_BIT:   ctrl.accKind = ACC_BIT;
      OP_SLA:   begin ctrl.modKind = MOD_SHL; ctrl.modFromAcc = 1'b1; ctrl.wrA = 1'b1; end
      OP_SRA:   begin ctrl.modKind = MOD_SHR; ctrl.modFromAcc = 1'b1; ctrl.wrA = 1'b1; end
      OP_RLA_A: begin ctrl.modKind = MOD_ROL; ctrl.modFromAcc = 1'b1; ctrl.wrA = 1'b1; end
      OP_RRA_A: begin ctrl.modKind = MOD_ROR; ctrl.modFromAcc = 1'b1; ctrl.wrA = 1'b1; end
      OP_SLM:   begin ctrl.modKind = MOD_SHL; ctrl.wrMem = 1'b1; end
      OP_SRM:   begin ctrl.modKind = MOD_SHR; ctrl.wrMem = 1'b1; end
      OP_RLM:   begin ctrl.modKind = MOD_ROL; ctrl.wrMem = 1'b1; end
      OP_RRM:   begin ctrl.modKind = MOD_ROR; ctrl.wrMem = 1'b1; end
      OP_INM:   begin ctrl.modKind = MOD_INC; ctrl.wrMem = 1'b1; end
      OP_DEM:   begin ctrl.modKind = MOD_DEC; ctrl.wrMem = 1'b1; end
      OP_FSO:   begin ctrl.modKind = MOD_SHL; ctrl.accKind = ACC_OR;
                      ctrl.wrMem = 1'b1; ctrl.wrA = 1'b1; end
      OP_FSX:   begin ctrl.modKind = MOD_SHR; ctrl.accKind = ACC_XOR;
                      ctrl.wrMem = 1'b1; ctrl.wrA = 1'b1; end
      OP_FRA:   begin ctrl.modKind = MOD_ROL; ctrl.accKind = ACC_AND;
                      ctrl.wrMem = 1'b1; ctrl.wrA = 1'b1; end
      OP_FRD:   begin ctrl.modKind = MOD_ROR; ctrl.accKind = ACC_ADD;
                      ctrl.wrMem = 1'b1; ctrl.wrA = 1'b1; end
      OP_FDC:   begin ctrl.modKind = MOD_DEC; ctrl.accKind = ACC_CMP;
                      ctrl.cmpSel = SEL_A; ctrl.wrMem = 1'b1; end
      OP_FIS:   begin ctrl.modKind = MOD_INC; ctrl.accKind = ACC_ADD; ctrl.invert = 1'b1;
                      ctrl.wrMem = 1'b1; ctrl.wrA = 1'b1; end
      default:  ctrl.flagWr = 1'b0;  // R13: unused opcodes touch no state
    endcase
  end

endmodule

// File: rtl/acc_alu_dp.sv
module acc_alu_dp
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  aluCtrl_t      ctrl,
  input  logic [DW-1:0] inOperand,
  output logic          outValid,
  output logic          outMemWr,
  output logic [DW-1:0] outMem,
  output logic [DW-1:0] regA,
  output logic [DW-1:0] regX,
  output logic [DW-1:0] regY,
  output logic          flagC,
  output logic          flagZ,
  output logic          flagV,
  output logic          flagN
);

  localparam int MSB = DW - 1;

  logic [DW-1:0] modSrc, modVal, opB, addB, cmpReg, res;
  logic          modC, nextC, nextV, nextN;
  logic [DW:0]   sum, diff;

  // Modify stage
  always_comb begin
    modSrc = ctrl.modFromAcc ? regA : inOperand;
    modVal = modSrc;
    modC   = flagC;
    case (ctrl.modKind)
      MOD_SHL: begin modVal = {modSrc[MSB-1:0], 1'b0};  modC = modSrc[MSB]; end
      MOD_SHR: begin modVal = {1'b0, modSrc[MSB:1]};    modC = modSrc[0];   end
      MOD_ROL: begin modVal = {modSrc[MSB-1:0], flagC}; modC = modSrc[MSB]; end
      MOD_ROR: begin modVal = {flagC, modSrc[MSB:1]};   modC = modSrc[0];   end
      MOD_INC: modVal = modSrc + 1'b1;
      MOD_DEC: modVal = modSrc - 1'b1;
      default: modVal = modSrc;
    endcase
  end

  // Accumulator stage
  always_comb begin
    opB  = (ctrl.modKind == MOD_NONE) ? inOperand : modVal;
    addB = ctrl.invert ? ~opB : opB;
    sum  = {1'b0, regA} + {1'b0, addB} + {{DW{1'b0}}, modC};
    case (ctrl.cmpSel)
      SEL_X:   cmpReg = regX;
      SEL_Y:   cmpReg = regY;
      default: cmpReg = regA;
    endcase
    diff  = {1'b0, cmpReg} - {1'b0, opB};
    nextC = modC;
    nextV = flagV;
    case (ctrl.accKind)
      ACC_LOAD: res = opB;
      ACC_ADD: begin
        res   = sum[MSB:0];
        nextC = sum[DW];
        nextV = (regA[MSB] == addB[MSB]) && (res[MSB] != regA[MSB]);
      end
      ACC_AND: res = regA & opB;
      ACC_OR:  res = regA | opB;
      ACC_XOR: res = regA ^ opB;
      ACC_CMP: begin
        res   = diff[MSB:0];
        nextC = ~diff[DW];
      end
      ACC_BIT: begin
        res   = regA & opB;
        nextV = opB[MSB-1];
      end
      default: res = modVal;
    endcase
    nextN = (ctrl.accKind == ACC_BIT) ? opB[MSB] : res[MSB];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regA     <= '0;
      regX     <= '0;
      regY     <= '0;
      outMem   <= '0;
      flagC    <= 1'b0;
      flagZ    <= 1'b0;
      flagV    <= 1'b0;
      flagN    <= 1'b0;
      outValid <= 1'b0;
      outMemWr <= 1'b0;
    end else begin
      outValid <= ctrl.fire;
      outMemWr <= ctrl.fire & ctrl.wrMem;
      if (ctrl.fire) begin
        if (ctrl.wrA)   regA   <= res;
        if (ctrl.wrX)   regX   <= res;
        if (ctrl.wrY)   regY   <= res;
        if (ctrl.wrMem) outMem <= modVal;
        if (ctrl.flagWr) begin
          flagC <= nextC;
          flagZ <= (res == '0);
          flagV <= nextV;
          flagN <= nextN;
        end
      end
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OP_W-1:0] inOp,
  input  logic [DW-1:0]   inOperand,
  output logic            outValid,
  output logic            outMemWr,
  output logic [DW-1:0]   outMem,
  output logic [DW-1:0]   regA,
  output logic [DW-1:0]   regX,
  output logic [DW-1:0]   regY,
  output logic            flagC,
  output logic            flagZ,
  output logic            flagV,
  output logic            flagN
);

  aluCtrl_t ctrl;

  acc_alu_ctrl u_ctrl (
    .inValid (inValid),
    .inOp    (inOp),
    .ctrl    (ctrl)
  );

  acc_alu_dp #(.DW(DW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .inOperand (inOperand),
    .outValid  (outValid),
    .outMemWr  (outMemWr),
    .outMem    (outMem),
    .regA      (regA),
    .regX      (regX),
    .regY      (regY),
    .flagC     (flagC),
    .flagZ     (flagZ),
    .flagV     (flagV),
    .flagN     (flagN)
  );

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          inValid,
  input logic [4:0]    inOp,
  input logic [DW-1:0] inOperand,
  input logic          outValid,
  input logic          outMemWr,
  input logic [DW-1:0] outMem,
  input logic [DW-1:0] regA,
  input logic [DW-1:0] regX,
  input logic [DW-1:0] regY,
  input logic          flagC,
  input logic          flagZ,
  input logic          flagV,
  input logic          flagN
);

  p_done_timing_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(regA) && $stable(regX) && $stable(regY) && $stable(outMem)
                 && $stable(flagC) && $stable(flagZ) && $stable(flagV) && $stable(flagN));

  p_load_zn_r3: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inOp == 5'd0 |=> regA == $past(inOperand) && flagZ == (regA == '0)
                                && flagN == regA[DW-1]);

  p_logic_hold_cv_r6: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (inOp == 5'd6 || inOp == 5'd7 || inOp == 5'd8) |=> $stable(flagC) && $stable(flagV));

  p_cmp_keeps_regs_r7: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (inOp == 5'd9 || inOp == 5'd10 || inOp == 5'd11)
      |=> $stable(regA) && $stable(regX) && $stable(regY) && $stable(flagV));

  p_bit_flags_r8: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inOp == 5'd12 |=> flagV == $past(inOperand[DW-2]) && flagN == $past(inOperand[DW-1])
                                 && $stable(regA));

  p_shr_n_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && (inOp == 5'd14 || inOp == 5'd18) |=> !flagN);

  p_inc_wrap_r11: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inOp == 5'd21 |=> outMem == DW'($past(inOperand) + 1'b1) && $stable(flagC)
                                 && $stable(flagV));

  p_memwr_with_done_r13: assert property (@(posedge clk) disable iff (!rstN)
    outMemWr |-> outValid);

endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (.*);

// File: tb/acc_alu_bench.sv
module acc_alu_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [4:0] inOp = '0;
  logic [7:0] inOperand = '0;
  logic       outValid, outMemWr, flagC, flagZ, flagV, flagN;
  logic [7:0] outMem, regA, regX, regY;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  int mA, mX, mY, mC, mZ, mV, mN, mMem, mValid, mWr;

  always #4 clk = ~clk;

  acc_alu u_acc_alu (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOp(inOp), .inOperand(inOperand),
    .outValid(outValid), .outMemWr(outMemWr), .outMem(outMem),
    .regA(regA), .regX(regX), .regY(regY),
    .flagC(flagC), .flagZ(flagZ), .flagV(flagV), .flagN(flagN)
  );

  function automatic int bit7(int x); return (x >> 7) & 1; endfunction
  function automatic void zn(int r); mZ = (r == 0); mN = bit7(r); endfunction

  function automatic void addc(int b);
    int t = mA + b + mC;
    int r = t % 256;
    mV = (bit7(mA) == bit7(b) && bit7(r) != bit7(mA)) ? 1 : 0;
    mC = (t > 255) ? 1 : 0;
    mA = r;
    zn(r);
  endfunction

  function automatic void cmpm(int r, int b);
    mC = (r >= b) ? 1 : 0;
    mZ = (r == b) ? 1 : 0;
    mN = bit7((r - b + 256) % 256);
  endfunction

  function automatic int shl(int x);
    int r = (x * 2) % 256; mC = bit7(x); zn(r); return r;
  endfunction
  function automatic int shr(int x);
    int r = x / 2; mC = x % 2; zn(r); return r;
  endfunction
  function automatic int rol(int x);
    int r = (x * 2) % 256 + mC; mC = bit7(x); zn(r); return r;
  endfunction
  function automatic int rorm(int x);
    int r = x / 2 + 128 * mC; mC = x % 2; zn(r); return r;
  endfunction

  function automatic void model(int op, int v);
    case (op)
      0:  begin mA = v; zn(v); end
      1:  begin mX = v; zn(v); end
      2:  begin mY = v; zn(v); end
      3:  begin mA = v; mX = v; zn(v); end
      4:  addc(v);
      5:  addc(255 - v);
      6:  begin mA = mA & v; zn(mA); end
      7:  begin mA = mA | v; zn(mA); end
      8:  begin mA = mA ^ v; zn(mA); end
      9:  cmpm(mA, v);
      10: cmpm(mX, v);
      11: cmpm(mY, v);
      12: begin mZ = ((mA & v) == 0); mV = (v >> 6) & 1; mN = bit7(v); end
      13: mA = shl(mA);
      14: mA = shr(mA);
      15: mA = rol(mA);
      16: mA = rorm(mA);
      17: mMem = shl(v);
      18: mMem = shr(v);
      19: mMem = rol(v);
      20: mMem = rorm(v);
      21: begin mMem = (v + 1) % 256; zn(mMem); end
      22: begin mMem = (v + 255) % 256; zn(mMem); end
      23: begin mMem = shl(v); mA = mA | mMem; zn(mA); end
      24: begin mMem = shr(v); mA = mA ^ mMem; zn(mA); end
      25: begin mMem = rol(v); mA = mA & mMem; zn(mA); end
      26: begin mMem = rorm(v); addc(mMem); end
      27: begin mMem = (v + 255) % 256; cmpm(mA, mMem); end
      28: begin mMem = (v + 1) % 256; addc(255 - mMem); end
      default: ;
    endcase
    mWr = (op >= 17 && op <= 28) ? 1 : 0;
  endfunction

  function automatic string tagOf(int op);
    if (op <= 3) return "R3";
    if (op == 4) return "R4";
    if (op == 5) return "R5";
    if (op <= 8) return "R6";
    if (op <= 11) return "R7";
    if (op == 12) return "R8";
    if (op == 13 || op == 14 || op == 17 || op == 18) return "R9";
    if (op == 15 || op == 16 || op == 19 || op == 20) return "R10";
    if (op == 21 || op == 22) return "R11";
    if (op <= 28) return "R12";
    return "R13";
  endfunction

  task automatic check(string tag);
    logic [37:0] act, exp;
    act = {regA, regX, regY, flagC, flagZ, flagV, flagN, outValid, outMemWr, outMem};
    exp = {8'(mA), 8'(mX), 8'(mY), 1'(mC), 1'(mZ), 1'(mV), 1'(mN),
           1'(mValid), 1'(mWr), 8'(mMem)};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (A X Y CZVN valid memwr mem)", tag, act, exp);
    end
  endtask

  // Called at a falling edge; checks at the next falling edge.
  task automatic runOp(int op, int v);
    inValid = 1'b1; inOp = 5'(op); inOperand = 8'(v);
    model(op, v);
    mValid = 1;
    @(negedge clk);
    inValid = 1'b0;
    check(tagOf(op));
  endtask

  task automatic idle();
    mValid = 0; mWr = 0;
    inOp = 5'd4; inOperand = 8'hFF;  // R2: stray inputs without strobe
    @(negedge clk);
    check("R2");
  endtask

  initial begin
    mA = 0; mX = 0; mY = 0; mC = 0; mZ = 0; mV = 0; mN = 0;
    mMem = 0; mValid = 0; mWr = 0;
    repeat (3) @(negedge clk);
    check("R1");
    rstN = 1'b1;
    @(negedge clk);
    check("R1");
    // R3 loads
    runOp(0, 8'h00); runOp(0, 8'h80); runOp(1, 8'h7F); runOp(2, 8'h01); runOp(3, 8'hC3);
    idle();
    // R4 add: carry-out and signed overflow
    runOp(0, 8'h50); runOp(4, 8'h50); runOp(4, 8'h60); runOp(0, 8'hFF); runOp(4, 8'h01);
    runOp(4, 8'hFF);
    // R5 subtract with carry clear then set
    runOp(0, 8'h00); runOp(4, 8'h00); runOp(0, 8'h10); runOp(5, 8'h05); runOp(5, 8'h0A);
    runOp(0, 8'h80); runOp(5, 8'h01);
    // R6 logic
    runOp(0, 8'hAA); runOp(6, 8'h0F); runOp(7, 8'h80); runOp(8, 8'h8A);
    // R7 compares
    runOp(0, 8'h18); runOp(9, 8'h18); runOp(9, 8'h19); runOp(9, 8'h17);
    runOp(1, 8'h00); runOp(10, 8'h01); runOp(2, 8'hFF); runOp(11, 8'h00);
    // R8 bit test
    runOp(0, 8'h18); runOp(12, 8'hE0); runOp(12, 8'h08); runOp(12, 8'h40);
    // R9, R10 shifts and rotates
    runOp(0, 8'h81); runOp(14, 0); runOp(13, 0); runOp(15, 0); runOp(16, 0);
    runOp(17, 8'h98); runOp(18, 8'h81); runOp(19, 8'h80); runOp(20, 8'h01);
    // R11 increment/decrement wrap
    runOp(21, 8'hFF); runOp(22, 8'h00); runOp(22, 8'h01); runOp(21, 8'h7F);
    // R12 fused
    runOp(0, 8'h01); runOp(23, 8'h81); runOp(24, 8'h03); runOp(25, 8'hC0);
    runOp(26, 8'h03); runOp(27, 8'h00); runOp(28, 8'h0F); runOp(28, 8'hFF);
    // R13 unused opcodes
    runOp(29, 8'h55); runOp(31, 8'h00);
    idle();
    for (int i = 0; i < 600; i++) begin
      runOp(int'($urandom_range(0, 31)), int'($urandom_range(0, 255)));
      if (i % 37 == 0) idle();
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R2: watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule